// File: doc/BRIEF.md
# Keyed-Clear Timebase with Synchronous Standby

This unit keeps a free-running 32-bit timebase and holds the standby request for its power domain. It sits on a byte-wide register bus. Each bus access is a one-cycle request that carries an address, a write flag, an access size code and write data. Read data returns on the cycle after the request.

The timebase cannot be cleared by a single stray write. It returns to zero only when two exact key bytes are written in order to a clear-command register. The standby control register holds the requested low-power mode. A control register selects how a write to the standby register takes effect.

- With immediate entry, the standby request rises on the cycle after the write.
- With synchronous entry, the write only arms the controller. A later read of the standby register starts a fixed countdown, and the request rises at the end of it.

An external wake pulse drops the request and removes any armed or counting state.

Top module: `keyed_timebase`

## Requirements
- R1: After reset the counter, control register, mode output, read data, error strobe and standby request are all zero.
- R2: The counter increments by one on every clock while the standby request is low. Its bytes read at addresses 0x484 (bits 7:0) through 0x487 (bits 31:24).
- R3: Writing 0xA5 and then 0x5A to address 0x483 sets the counter to zero on the edge that takes the second write. A read issued k idle cycles after that write returns k.
- R4: Any other byte after 0xA5, including a second 0xA5, returns the key checker to idle without clearing. The same holds for any first byte other than 0xA5. A following correct pair still clears.
- R5: Addresses 0x481 and 0x483 take byte accesses only (size code 0). An access there with size code 1 or 2 has no effect, and bus_err_o is high for exactly the one cycle after it.
- R6: The control register is 16 bits wide. Bits 7:0 are at 0x488 and bits 15:8 at 0x489, both read/write. Bit 8 (bit 0 of the byte at 0x489) selects synchronous standby.
- R7: With bit 8 clear, a byte write to 0x481 latches the mode on stby_mode_o, and stby_req_o is high on the next cycle.
- R8: With bit 8 set, a write to 0x481 latches the mode and only arms the controller. The first read of 0x481 while armed makes stby_req_o rise exactly 5 cycles after that read. A following dummy read does not restart the countdown.
- R9: A wake pulse clears stby_req_o on the next cycle and discards the armed state, so a later read of 0x481 starts nothing.
- R10: While stby_req_o is high the counter holds its value.
- R11: Read data for address 0x481 is the latched mode. It appears on bus_rdata_o on the cycle after the read request and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read |
| bus_err_o | output | 1 | One-cycle strobe after a wrong-size access |
| wake_i | input | 1 | Wake pulse, clears standby |
| stby_req_o | output | 1 | Standby request |
| stby_mode_o | output | 8 | Latched standby mode |

## Verification
Every result has a fixed latency from the edge that samples its access:
- The counter clear and the register updates take effect on that same edge.
- Read data, the error strobe and the immediate standby request are visible one cycle later.
- The synchronous request is visible five edges after the triggering read.

The bench drives inputs at falling edges and counts falling edges from the sampling edge to the cycle where each result is due. A scoreboard queue pairs every accepted read with its expected byte, so read values are compared on the cycle after the read. Counter values are predicted as the number of idle cycles since a known clear, which pins down both the clear and the hold behaviour.

// File: rtl/keyed_tb_pkg.sv
package keyed_tb_pkg;
  localparam int ADDR_W   = 12;
  localparam int CTL_W    = 16;
  localparam int SYNC_BIT = 8;

  localparam logic [ADDR_W-1:0] A_STBY = 12'h481;
  localparam logic [ADDR_W-1:0] A_KEY  = 12'h483;
  localparam logic [ADDR_W-1:0] A_CNT  = 12'h484;
  localparam logic [ADDR_W-1:0] A_CTL  = 12'h488;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  localparam logic [1:0] SZ_BYTE = 2'd0;

  typedef enum logic {KEY_IDLE, KEY_HALF} key_state_e;

  typedef struct packed {
    logic stby_wr;
    logic stby_rd;
    logic key_wr;
    logic ctl_lo_wr;
    logic ctl_hi_wr;
    logic rd_en;
    logic size_err;
  } dec_t;
endpackage

// File: rtl/keyed_tb_regif.sv
module keyed_tb_regif
  import keyed_tb_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output dec_t              dec_o
);
  logic byte_only;
  logic size_ok;
  logic bad;

  always_comb begin
    byte_only       = (addr_i == A_STBY) || (addr_i == A_KEY);
    size_ok         = (size_i == SZ_BYTE);
    bad             = req_i && byte_only && !size_ok;
    dec_o.size_err  = bad;
    dec_o.rd_en     = req_i && !we_i && !bad;
    dec_o.stby_wr   = req_i && we_i  && size_ok && (addr_i == A_STBY);
    dec_o.stby_rd   = req_i && !we_i && size_ok && (addr_i == A_STBY);
    dec_o.key_wr    = req_i && we_i  && size_ok && (addr_i == A_KEY);
    dec_o.ctl_lo_wr = req_i && we_i  && (addr_i == A_CTL);
    dec_o.ctl_hi_wr = req_i && we_i  && (addr_i == A_CTL + ADDR_W'(1));
  end
endmodule

// File: rtl/keyed_tb_key_chk.sv
module keyed_tb_key_chk
  import keyed_tb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] wdata_i,
  output logic       clr_o
);
  key_state_e state_q;

  // clear takes effect on the edge of the second key write
  assign clr_o = key_wr_i && (state_q == KEY_HALF) && (wdata_i == KEY_SECOND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_IDLE;
    end else if (key_wr_i) begin
      if (state_q == KEY_IDLE && wdata_i == KEY_FIRST) state_q <= KEY_HALF;
      else                                              state_q <= KEY_IDLE;
    end
  end
endmodule

// File: rtl/keyed_tb_counter.sv
module keyed_tb_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (!hold_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/keyed_tb_stby.sv
module keyed_tb_stby #(
  parameter int STBY_DLY = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       sync_en_i,
  input  logic       wake_i,
  input  logic [7:0] wdata_i,
  output logic       req_o,
  output logic       pend_o,
  output logic [7:0] mode_o
);
  localparam int DLY_W = $clog2(STBY_DLY + 1);

  logic             armed_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= '0;
    else if (wr_i) mode_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      armed_q <= 1'b0;
      pend_o  <= 1'b0;
      dly_q   <= '0;
    end else if (wake_i) begin
      req_o   <= 1'b0;
      armed_q <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (wr_i) begin
        if (sync_en_i) armed_q <= 1'b1;
        else           req_o   <= 1'b1;
      end
      if (pend_o) begin
        if (dly_q == '0) begin
          req_o  <= 1'b1;
          pend_o <= 1'b0;
        end else begin
          dly_q <= dly_q - DLY_W'(1);
        end
      end else if (rd_i && armed_q) begin
        // later reads while counting down are dummies
        pend_o  <= 1'b1;
        armed_q <= 1'b0;
        dly_q   <= DLY_W'(STBY_DLY - 1);
      end
    end
  end
endmodule

// File: rtl/keyed_timebase.sv
module keyed_timebase
  import keyed_tb_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int STBY_DLY = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_err_o,
  input  logic              wake_i,
  output logic              stby_req_o,
  output logic [7:0]        stby_mode_o
);
  localparam int CNT_BYTES = CNT_W / 8;

  dec_t             dec;
  logic             key_clr;
  logic             stby_pend;
  logic [CNT_W-1:0] cnt_q;
  logic [CTL_W-1:0] ctl_q;
  logic             sync_en;
  logic [7:0]       rd_mux;

  keyed_tb_regif u_regif (
    .req_i  (bus_req_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .size_i (bus_size_i),
    .dec_o  (dec)
  );

  keyed_tb_key_chk u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (dec.key_wr),
    .wdata_i  (bus_wdata_i),
    .clr_o    (key_clr)
  );

  keyed_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (key_clr),
    .hold_i (stby_req_o),
    .cnt_o  (cnt_q)
  );

  keyed_tb_stby #(.STBY_DLY(STBY_DLY)) u_stby (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (dec.stby_wr),
    .rd_i      (dec.stby_rd),
    .sync_en_i (sync_en),
    .wake_i    (wake_i),
    .wdata_i   (bus_wdata_i),
    .req_o     (stby_req_o),
    .pend_o    (stby_pend),
    .mode_o    (stby_mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (dec.ctl_lo_wr) ctl_q[7:0]  <= bus_wdata_i;
      if (dec.ctl_hi_wr) ctl_q[15:8] <= bus_wdata_i;
    end
  end

  assign sync_en = ctl_q[SYNC_BIT];

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == A_STBY)               rd_mux = stby_mode_o;
    if (bus_addr_i == A_CTL)                rd_mux = ctl_q[7:0];
    if (bus_addr_i == A_CTL + ADDR_W'(1))   rd_mux = ctl_q[15:8];
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (bus_addr_i == A_CNT + ADDR_W'(i)) rd_mux = cnt_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      bus_err_o <= dec.size_err;
      if (dec.rd_en) bus_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/keyed_timebase_chk.sv
module keyed_timebase_chk
  import keyed_tb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [1:0]        bus_size_i,
  input logic              bus_err_o,
  input logic              wake_i,
  input logic              stby_req_o,
  input logic              key_clr,
  input logic              sync_en,
  input logic              stby_pend,
  input logic [CNT_W-1:0]  cnt_q
);
  logic stby_byte_wr;
  logic odd_size;

  assign stby_byte_wr = bus_req_i && bus_we_i && (bus_addr_i == A_STBY) && (bus_size_i == 2'd0);
  assign odd_size     = bus_req_i && (bus_size_i != 2'd0) &&
                        ((bus_addr_i == A_STBY) || (bus_addr_i == A_KEY));

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_req_o && !key_clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3
  key_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_clr |=> (cnt_q == '0));

  // R5
  size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_size |=> bus_err_o);

  // R5
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odd_size |=> !bus_err_o);

  // R7
  direct_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_byte_wr && !sync_en && !wake_i) |=> stby_req_o);

  // R8
  sync_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_byte_wr && sync_en && !wake_i && !stby_req_o && !stby_pend) |=> !stby_req_o);

  // R9
  wake_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !stby_req_o);

  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_req_o && !key_clr) |=> $stable(cnt_q));
endmodule

bind keyed_timebase keyed_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_size_i (bus_size_i),
  .bus_err_o  (bus_err_o),
  .wake_i     (wake_i),
  .stby_req_o (stby_req_o),
  .key_clr    (key_clr),
  .sync_en    (sync_en),
  .stby_pend  (stby_pend),
  .cnt_q      (cnt_q)
);

// File: tb/tb_keyed_timebase.sv
`timescale 1ns/1ps
module tb_keyed_timebase;
  localparam logic [11:0] A_STBY = 12'h481;
  localparam logic [11:0] A_KEY  = 12'h483;
  localparam logic [11:0] A_CNT  = 12'h484;
  localparam logic [11:0] A_CTL  = 12'h488;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic        wake = 1'b0;
  logic        stby_req;
  logic [7:0]  stby_mode;

  int checks = 0;
  int fails  = 0;
  rd_item_t exp_q[$];

  always #5 clk = ~clk;

  keyed_timebase dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_req_i   (bus_req),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_size_i  (bus_size),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .bus_err_o   (bus_err),
    .wake_i      (wake),
    .stby_req_o  (stby_req),
    .stby_mode_o (stby_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the falling edge after the sampling edge
  task automatic bus_op(input logic we, input logic [11:0] a, input logic [1:0] sz, input logic [7:0] d);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_op(1'b1, a, 2'd0, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.tag = tag; it.exp = exp;
    exp_q.push_back(it);
    bus_op(1'b0, a, 2'd0, 8'h00);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cnt();
    wr(A_KEY, 8'hA5);
    wr(A_KEY, 8'h5A);
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // monitor: pops the expected byte for every accepted read, one cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_req && !bus_we &&
          !((bus_addr == A_STBY || bus_addr == A_KEY) && bus_size != 2'd0)) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("R11 unexpected read", 32'(bus_rdata), 32'hFFFF_FFFF);
        end else begin
          rd_item_t it;
          it = exp_q.pop_front();
          chk(it.tag, 32'(bus_rdata), 32'(it.exp));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 err", 32'(bus_err), 0);
    chk("R1 req", 32'(stby_req), 0);
    chk("R1 mode", 32'(stby_mode), 0);
    rst_n = 1'b1;
    idle(1);
    rd(A_CTL, 8'h00, "R1 ctl lo");
    rd(A_CTL + 12'd1, 8'h00, "R1 ctl hi");

    // R6 control register readback
    wr(A_CTL, 8'h3C);
    rd(A_CTL, 8'h3C, "R6 ctl lo");
    rd(A_CTL + 12'd1, 8'h00, "R6 ctl hi");

    // R3 key clear
    clear_cnt();
    rd(A_CNT, 8'd0, "R3 immediate");
    clear_cnt();
    idle(3);
    rd(A_CNT, 8'd3, "R3 after 3");

    // R2 byte positions
    clear_cnt();
    idle(299);
    rd(A_CNT + 12'd1, 8'h01, "R2 byte1");
    rd(A_CNT, 8'h2C, "R2 byte0");
    rd(A_CNT + 12'd2, 8'h00, "R2 byte2");
    rd(A_CNT + 12'd3, 8'h00, "R2 byte3");

    // R4 broken keys
    clear_cnt();
    wr(A_KEY, 8'hA5); wr(A_KEY, 8'h33); wr(A_KEY, 8'h5A);
    rd(A_CNT, 8'd3, "R4 bad second");
    clear_cnt();
    wr(A_KEY, 8'hA5); wr(A_KEY, 8'hA5); wr(A_KEY, 8'h5A);
    rd(A_CNT, 8'd3, "R4 double first");
    clear_cnt();
    wr(A_KEY, 8'h5A); wr(A_KEY, 8'h5A); wr(A_KEY, 8'h77);
    rd(A_CNT, 8'd3, "R4 bad first");
    wr(A_KEY, 8'h11);
    clear_cnt();
    rd(A_CNT, 8'd0, "R4 recover");

    // R5 wrong-size accesses
    clear_cnt();
    bus_op(1'b1, A_KEY, 2'd1, 8'hA5);
    chk("R5 err key wr", 32'(bus_err), 1);
    wr(A_KEY, 8'h5A);
    chk("R5 err one cycle", 32'(bus_err), 0);
    rd(A_CNT, 8'd2, "R5 key ignored");
    bus_op(1'b1, A_STBY, 2'd2, 8'h55);
    chk("R5 err stby wr", 32'(bus_err), 1);
    chk("R5 no req", 32'(stby_req), 0);
    chk("R5 mode kept", 32'(stby_mode), 0);
    bus_op(1'b0, A_STBY, 2'd1, 8'h00);
    chk("R5 err stby rd", 32'(bus_err), 1);
    idle(1);
    chk("R5 err drop", 32'(bus_err), 0);

    // R7 immediate standby, R10 hold, R9 wake
    clear_cnt();
    wr(A_STBY, 8'h07);
    chk("R7 req", 32'(stby_req), 1);
    chk("R7 mode", 32'(stby_mode), 32'h07);
    rd(A_CNT, 8'd1, "R10 held");
    idle(10);
    rd(A_CNT, 8'd1, "R10 still held");
    pulse_wake();
    chk("R9 wake clears", 32'(stby_req), 0);

    // R8 synchronous standby
    wr(A_CTL + 12'd1, 8'h01);
    rd(A_CTL + 12'd1, 8'h01, "R6 sync bit");
    wr(A_STBY, 8'h03);
    chk("R8 armed no req", 32'(stby_req), 0);
    idle(3);
    chk("R8 armed still low", 32'(stby_req), 0);
    rd(A_STBY, 8'h03, "R11 mode read");
    rd(A_STBY, 8'h03, "R8 dummy read");
    idle(3);
    chk("R8 low at 4", 32'(stby_req), 0);
    idle(1);
    chk("R8 high at 5", 32'(stby_req), 1);
    pulse_wake();
    chk("R9 wake sync", 32'(stby_req), 0);

    // R9 wake discards armed state
    wr(A_STBY, 8'h04);
    pulse_wake();
    rd(A_STBY, 8'h04, "R9 read after wake");
    idle(7);
    chk("R9 no trigger", 32'(stby_req), 0);

    idle(2);
    chk("R11 queue drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule